// File: doc/BRIEF.md
# Single-Channel Bus-Master DMA with Shadow Address Reload

The block is one DMA channel that moves 32-bit words between a memory port and one peripheral. Software programs it through a small register port holding a control/status word, a live address/count pair and a shadow address/count pair. Once started, the channel issues bursts of a programmable length on a request/acknowledge memory interface. It advances the address by one word per transfer and counts the remaining bytes down.

When the count runs out the channel flags terminal count. If a shadow pair has been armed, the channel swaps it into the live registers in the same cycle and carries on without software help. If no shadow pair is armed, the channel goes quiet. A bus error can halt the channel, and an interrupt line summarises the completion and error conditions. A software reset bit parks the channel. The channel will not release that reset while a memory request is still open.

Top module: `dma_chan`

## Requirements
- R1: After reset, offset 0x0 reads 0xC000_0000 (device ID 0xC in bits 31:28, every other bit 0), offsets 0x4 and 0x8 read 0, mem_req_o is 0 and irq_o is 0.
- R2: Writes to offset 0x4 (address) and 0x8 (byte count) load the shadow registers when the reload-enable bit 11 is 1 and the live registers when it is 0. Reads at 0x4 and 0x8 always return the live registers. Counts are multiples of 4, and bits 1:0 of a count write are ignored.
- R3: Control bits 13:12 set the burst length in words: 00 gives 4, 01 gives 8, 10 gives 1 and 11 gives 16. mem_req_o stays high from the start of a burst until its last word is acknowledged, and stays low for at least one cycle between bursts.
- R4: With the run bit 5 and the count-enable bit 7 set, each acknowledged word adds 4 to the address and subtracts 4 from the count. A burst is cut short to the number of words still remaining.
- R5: The terminal-count flag (bit 8) is set when the count reaches 0. Writing 1 to bit 8 clears it, and a set in the same cycle takes priority over the clear. Without a reload, the active status (bit 14) drops and no further requests are issued.
- R6: At terminal count, if bit 11, bit 7 and the shadow-loaded flag (bit 16) are all set, the shadow address and count move into the live registers, bit 16 clears and the channel keeps running. Bit 16 is set by a shadow address write. Bit 15 is set by a live address write or by a reload, and is cleared at a terminal count that has no reload.
- R7: An acknowledged word with mem_err_i high sets the error flag (bit 1, write 1 to clear). Unless the no-stop-on-error bit 9 is set, the channel stops after that word until the flag is cleared.
- R8: Bit 0 reads as terminal count masked by the TC-interrupt-disable bit 10. irq_o equals interrupt-enable bit 2 AND (bit 0 OR (bit 1 AND NOT bit 9)).
- R9: While the soft-reset bit 3 is 1, no new request is issued. A write of 0 to bit 3 has no effect while the cycle-pending flag (bit 6, an open memory request) is 1.
- R10: Direction bit 4 = 0 reads memory, with mem_we_o low and dev_data_o equal to mem_rdata_i. Bit 4 = 1 writes memory, with mem_we_o high and mem_wdata_o equal to dev_data_i. dev_strobe_o is high in each cycle a word is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select (byte offset bits 3:2) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write (device to memory) |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one word per cycle |
| mem_err_i | input | 1 | Error qualifier for the acknowledged word |
| mem_rdata_i | input | DATA_W | Memory read data |
| dev_data_i | input | DATA_W | Peripheral data toward memory |
| dev_data_o | output | DATA_W | Data toward the peripheral |
| dev_strobe_o | output | 1 | Word transferred to or from the peripheral |
| irq_o | output | 1 | Interrupt request |

## Verification
Terminal count can be set by the final acknowledged word in the same cycle that software writes 1 to clear it. The bench provokes this by taking over the acknowledge line. It then drives the last word's acknowledge and a control write carrying the clear bit on the same clock edge. The result is judged by reading bit 8 back: it must still be 1. Random transfers over all four burst codes, both directions and counts up to 40 words check burst splitting, address order and data routing against a bench model.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [3:0] DEV_ID = 4'hC;

  // control/status bit positions
  localparam int CB_IPEND  = 0;
  localparam int CB_EPEND  = 1;
  localparam int CB_IEN    = 2;
  localparam int CB_SRST   = 3;
  localparam int CB_DIR    = 4;
  localparam int CB_RUN    = 5;
  localparam int CB_CPEND  = 6;
  localparam int CB_CNTEN  = 7;
  localparam int CB_TC     = 8;
  localparam int CB_NOESTP = 9;
  localparam int CB_NOTCI  = 10;
  localparam int CB_AUTO   = 11;
  localparam int CB_BLO    = 12;
  localparam int CB_ACTIVE = 14;
  localparam int CB_ALOAD  = 15;
  localparam int CB_NLOAD  = 16;

  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_ADDR = 2'd1, SEL_CNT = 2'd2, SEL_NONE = 2'd3} reg_sel_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_st_e;

  function automatic logic [4:0] burst_words(input logic [1:0] code);
    unique case (code)
      2'b00:   return 5'd4;
      2'b01:   return 5'd8;
      2'b10:   return 5'd1;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              word_done_i,
  input  logic              err_i,
  input  logic              cyc_pend_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-3:0]  cnt_words_o,
  output logic              cnt_en_o,
  output logic [1:0]        burst_o,
  output logic              dir_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              irq_o
);
  localparam int CW = CNT_W - 2;

  logic int_en, soft_rst, dir, run_en, cnt_en, no_err_stop, no_tc_irq, autoload;
  logic [1:0] burst;
  logic tc, err_pend, a_loaded, n_loaded;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [CW-1:0] cur_words, nxt_words;

  logic wr_ctrl, wr_addr, wr_cnt, tc_hit, reload, err_stop, int_pend, active;
  logic [31:0] ctrl_rd;

  assign wr_ctrl  = wr_i && (reg_sel_e'(sel_i) == SEL_CTRL);
  assign wr_addr  = wr_i && (reg_sel_e'(sel_i) == SEL_ADDR);
  assign wr_cnt   = wr_i && (reg_sel_e'(sel_i) == SEL_CNT);
  assign tc_hit   = word_done_i && cnt_en && (cur_words == CW'(1));
  assign reload   = tc_hit && autoload && n_loaded;
  assign err_stop = err_pend && !no_err_stop;
  assign int_pend = tc && !no_tc_irq;
  assign active   = run_en && !soft_rst && !err_stop && !(cnt_en && cur_words == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en <= 1'b0; soft_rst <= 1'b0; dir <= 1'b0; run_en <= 1'b0;
      cnt_en <= 1'b0; no_err_stop <= 1'b0; no_tc_irq <= 1'b0; autoload <= 1'b0;
      burst <= 2'b00; tc <= 1'b0; err_pend <= 1'b0;
      a_loaded <= 1'b0; n_loaded <= 1'b0;
      cur_addr <= '0; nxt_addr <= '0; cur_words <= '0; nxt_words <= '0;
    end else begin
      if (wr_ctrl) begin
        int_en      <= wdata_i[CB_IEN];
        dir         <= wdata_i[CB_DIR];
        run_en      <= wdata_i[CB_RUN];
        cnt_en      <= wdata_i[CB_CNTEN];
        no_err_stop <= wdata_i[CB_NOESTP];
        no_tc_irq   <= wdata_i[CB_NOTCI];
        autoload    <= wdata_i[CB_AUTO];
        burst       <= wdata_i[CB_BLO+1:CB_BLO];
        // release refused while a request is open
        soft_rst    <= wdata_i[CB_SRST] | (soft_rst & cyc_pend_i);
      end
      if (tc_hit) tc <= 1'b1;
      else if (wr_ctrl && wdata_i[CB_TC]) tc <= 1'b0;
      if (err_i) err_pend <= 1'b1;
      else if (wr_ctrl && wdata_i[CB_EPEND]) err_pend <= 1'b0;

      if (reload) cur_addr <= nxt_addr;
      else if (word_done_i) cur_addr <= cur_addr + ADDR_W'(4);
      else if (wr_addr && !autoload) cur_addr <= wdata_i[ADDR_W-1:0];

      if (reload) cur_words <= nxt_words;
      else if (word_done_i && cnt_en) cur_words <= cur_words - CW'(1);
      else if (wr_cnt && !autoload) cur_words <= wdata_i[CNT_W-1:2];

      if (wr_addr && autoload) nxt_addr <= wdata_i[ADDR_W-1:0];
      if (wr_cnt && autoload) nxt_words <= wdata_i[CNT_W-1:2];

      if (wr_addr && autoload) n_loaded <= 1'b1;
      else if (reload) n_loaded <= 1'b0;

      if (reload || (wr_addr && !autoload)) a_loaded <= 1'b1;
      else if (tc_hit) a_loaded <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[31:28]            = DEV_ID;
    ctrl_rd[CB_IPEND]         = int_pend;
    ctrl_rd[CB_EPEND]         = err_pend;
    ctrl_rd[CB_IEN]           = int_en;
    ctrl_rd[CB_SRST]          = soft_rst;
    ctrl_rd[CB_DIR]           = dir;
    ctrl_rd[CB_RUN]           = run_en;
    ctrl_rd[CB_CPEND]         = cyc_pend_i;
    ctrl_rd[CB_CNTEN]         = cnt_en;
    ctrl_rd[CB_TC]            = tc;
    ctrl_rd[CB_NOESTP]        = no_err_stop;
    ctrl_rd[CB_NOTCI]         = no_tc_irq;
    ctrl_rd[CB_AUTO]          = autoload;
    ctrl_rd[CB_BLO+1:CB_BLO]  = burst;
    ctrl_rd[CB_ACTIVE]        = active;
    ctrl_rd[CB_ALOAD]         = a_loaded;
    ctrl_rd[CB_NLOAD]         = n_loaded;
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_CTRL: rdata_o = ctrl_rd;
      SEL_ADDR: rdata_o = 32'(cur_addr);
      SEL_CNT:  rdata_o = 32'({cur_words, 2'b00});
      default:  rdata_o = '0;
    endcase
  end

  assign cur_addr_o  = cur_addr;
  assign cnt_words_o = cur_words;
  assign cnt_en_o    = cnt_en;
  assign burst_o     = burst;
  assign dir_o       = dir;
  assign go_o        = active;
  assign halt_o      = soft_rst || !run_en || err_stop || (err_i && !no_err_stop);
  assign irq_o       = int_en && (int_pend || err_stop);

  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && !reload) |=> (cur_addr == $past(cur_addr) + ADDR_W'(4)));
  // R5
  tc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit |=> tc);
  // R6
  reload_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !(wr_addr && autoload)) |=> !n_loaded);
  // R7
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_pend);
  // R9
  srst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst) |-> !$past(cyc_pend_i));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             cnt_en_i,
  input  logic [1:0]       burst_i,
  input  logic [CNT_W-3:0] cnt_words_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic             word_done_o
);
  localparam int CW = CNT_W - 2;

  seq_st_e    state;
  logic [4:0] left;
  logic [4:0] cfg_len, len;

  assign cfg_len = burst_words(burst_i);
  // shorten to what remains
  assign len = (cnt_en_i && cnt_words_i < CW'(cfg_len)) ? cnt_words_i[4:0] : cfg_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      left  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go_i) begin
          state <= ST_BUSY;
          left  <= len;
        end
        ST_BUSY: if (ack_i) begin
          left <= left - 5'd1;
          if (left == 5'd1 || halt_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_o       = (state == ST_BUSY);
  assign word_done_o = req_o && ack_i;

  // R3
  burst_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BUSY) |-> (left != 5'd0));
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [3:2]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_strobe_o,
  output logic              irq_o
);
  logic             word_done, err_word, go, halt, cnt_en, dir, req;
  logic [1:0]       burst;
  logic [CNT_W-3:0] cnt_words;

  assign err_word = word_done && mem_err_i;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .sel_i       (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .word_done_i (word_done),
    .err_i       (err_word),
    .cyc_pend_i  (req),
    .cur_addr_o  (mem_addr_o),
    .cnt_words_o (cnt_words),
    .cnt_en_o    (cnt_en),
    .burst_o     (burst),
    .dir_o       (dir),
    .go_o        (go),
    .halt_o      (halt),
    .irq_o       (irq_o)
  );

  dma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .halt_i      (halt),
    .cnt_en_i    (cnt_en),
    .burst_i     (burst),
    .cnt_words_i (cnt_words),
    .ack_i       (mem_ack_i),
    .req_o       (req),
    .word_done_o (word_done)
  );

  assign mem_req_o    = req;
  assign mem_we_o     = dir;
  assign mem_wdata_o  = dev_data_i;
  assign dev_data_o   = mem_rdata_i;
  assign dev_strobe_o = word_done;
endmodule

// File: tb/sim_dma_chan.sv
`timescale 1ns/1ps
module sim_dma_chan;
  localparam int B_IP = 0, B_EP = 1, B_SR = 3, B_CP = 6, B_TC = 8, B_ACT = 14, B_AL = 15, B_NL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_err = 1'b0, dev_stb, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, dev_din = '0, dev_dout;
  logic        auto_mode = 1'b1, auto_ack = 1'b0, man_ack = 1'b0;
  wire         mem_ack = auto_mode ? auto_ack : man_ack;

  int total = 0, bad = 0, data_total = 0, data_bad = 0;
  int nlog = 0, nb = 0, err_word = -1;
  bit gap = 1'b1;
  logic [31:0] log_addr [1024];
  logic        log_we   [1024];
  int          blen     [512];

  always #2.5 clk = ~clk;

  dma_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .dev_data_i(dev_din), .dev_data_o(dev_dout), .dev_strobe_o(dev_stb), .irq_o(irq)
  );

  // memory model: random acknowledge, logs words and bursts, checks data routing (R10)
  always @(negedge clk) begin
    if (!mem_req) gap = 1'b1;
    auto_ack = 1'b0;
    mem_err  = 1'b0;
    if (auto_mode && rst_n && mem_req && ($urandom % 4 != 0)) begin
      auto_ack  = 1'b1;
      mem_err   = (nlog == err_word);
      mem_rdata = $urandom;
      dev_din   = $urandom;
      if (nlog < 1024) begin
        log_addr[nlog] = mem_addr;
        log_we[nlog]   = mem_we;
      end
      nlog++;
      if (gap) begin
        if (nb < 512) blen[nb] = 0;
        nb++;
        gap = 1'b0;
      end
      if (nb - 1 < 512) blen[nb-1]++;
      #1;
      data_total++;
      if (!dev_stb) begin
        data_bad++;
        $display("FAIL R10 strobe act=%0d exp=1", dev_stb);
      end else if (mem_we && mem_wdata !== dev_din) begin
        data_bad++;
        $display("FAIL R10 wdata act=%h exp=%h", mem_wdata, dev_din);
      end else if (!mem_we && dev_dout !== mem_rdata) begin
        data_bad++;
        $display("FAIL R10 dev data act=%h exp=%h", dev_dout, mem_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input bit run, input bit cnt, input bit aut, input logic [1:0] bc,
                                     input bit dir, input bit ien, input bit noe, input bit notc,
                                     input bit srst, input bit ctc, input bit cerr);
    logic [31:0] v = '0;
    v[5] = run; v[7] = cnt; v[11] = aut; v[13:12] = bc; v[4] = dir; v[2] = ien;
    v[9] = noe; v[10] = notc; v[3] = srst; v[8] = ctc; v[1] = cerr;
    return v;
  endfunction

  function automatic int bw(input logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 8;
      2'b10: return 1;
      default: return 16;
    endcase
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(2'd0, v);
      if (!v[B_ACT] && !mem_req) break;
    end
  endtask

  // compare logged bursts and addresses with the expected split
  task automatic chk_stream(input int lb, input int bb, input logic [31:0] a, input int words,
                            input logic [1:0] bc, input bit dir);
    int rem = words, i = bb;
    while (rem > 0) begin
      int l = (rem < bw(bc)) ? rem : bw(bc);
      chk("R3 burst length", blen[i], l);
      i++; rem -= l;
    end
    chk("R3 burst count", nb, i);
    chk("R4 word count", nlog - lb, words);
    for (int j = 0; j < words; j++) begin
      chk("R4 address", log_addr[lb+j], a + 32'(4 * j));
      chk("R10 direction", 32'(log_we[lb+j]), 32'(dir));
    end
  endtask

  task automatic run_xfer(input logic [31:0] a, input int words, input logic [1:0] bc, input bit dir);
    logic [31:0] v;
    int lb, bb;
    wr(2'd0, mk(0, 1, 0, bc, dir, 1, 0, 0, 0, 1, 1));
    wr(2'd1, a);
    wr(2'd2, 32'(words * 4));
    lb = nlog; bb = nb;
    wr(2'd0, mk(1, 1, 0, bc, dir, 1, 0, 0, 0, 0, 0));
    wait_idle();
    chk_stream(lb, bb, a, words, bc, dir);
    rd(2'd1, v); chk("R4 final address", v, a + 32'(4 * words));
    rd(2'd2, v); chk("R4 final count", v, 32'd0);
    rd(2'd0, v);
    chk("R5 tc set", 32'(v[B_TC]), 32'd1);
    chk("R5 active low", 32'(v[B_ACT]), 32'd0);
    chk("R8 int pend", 32'(v[B_IP]), 32'd1);
    chk("R6 a_loaded cleared", 32'(v[B_AL]), 32'd0);
    chk("R8 irq", 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total + data_total + 1, bad + data_bad + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lb, bb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl reset", v, 32'hC000_0000);
    rd(2'd1, v); chk("R1 addr reset", v, 32'd0);
    rd(2'd2, v); chk("R1 count reset", v, 32'd0);
    chk("R1 req reset", 32'(mem_req), 32'd0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    rd(2'd0, v); chk("R1 ctrl after release", v, 32'hC000_0000);

    // directed bursts: 4,4,2 / 16,4 / 1,1,1
    run_xfer(32'h0000_1000, 10, 2'b00, 1'b0);
    run_xfer(32'h0002_0000, 20, 2'b11, 1'b1);
    run_xfer(32'h0000_3000, 3, 2'b10, 1'b0);

    // R5 write-1-clear, R8 irq drops
    wr(2'd0, mk(0, 1, 0, 2'b00, 0, 1, 0, 0, 0, 1, 0));
    rd(2'd0, v); chk("R5 tc cleared", 32'(v[B_TC]), 32'd0);
    chk("R8 irq after clear", 32'(irq), 32'd0);

    // random transfers
    for (int n = 0; n < 10; n++) begin
      logic [1:0] bc = 2'($urandom % 4);
      int words = 1 + int'($urandom % 40);
      bit dir = 1'($urandom % 2);
      logic [31:0] a = $urandom & 32'h00FF_FFFC;
      run_xfer(a, words, bc, dir);
    end

    // R2/R6 autoload
    wr(2'd0, mk(0, 1, 0, 2'b01, 0, 1, 0, 0, 0, 1, 1));
    wr(2'd1, 32'h0000_4000);
    wr(2'd2, 32'd23);
    wr(2'd0, mk(0, 1, 1, 2'b01, 0, 1, 0, 0, 0, 0, 0));
    wr(2'd1, 32'h0000_8000);
    wr(2'd2, 32'd12);
    rd(2'd1, v); chk("R2 live addr kept", v, 32'h0000_4000);
    rd(2'd2, v); chk("R2 live count kept low bits dropped", v, 32'd20);
    rd(2'd0, v);
    chk("R6 n_loaded set", 32'(v[B_NL]), 32'd1);
    chk("R6 a_loaded set", 32'(v[B_AL]), 32'd1);
    lb = nlog; bb = nb;
    wr(2'd0, mk(1, 1, 1, 2'b01, 0, 1, 0, 0, 0, 0, 0));
    wait_idle();
    chk("R6 total words", nlog - lb, 8);
    chk("R6 burst count", nb - bb, 2);
    chk("R6 first burst", blen[bb], 5);
    chk("R6 second burst", blen[bb+1], 3);
    for (int j = 0; j < 5; j++) chk("R6 live stream", log_addr[lb+j], 32'h0000_4000 + 32'(4 * j));
    for (int j = 0; j < 3; j++) chk("R6 reloaded stream", log_addr[lb+5+j], 32'h0000_8000 + 32'(4 * j));
    rd(2'd0, v);
    chk("R6 n_loaded cleared", 32'(v[B_NL]), 32'd0);
    chk("R6 a_loaded cleared", 32'(v[B_AL]), 32'd0);
    chk("R5 tc after reload run", 32'(v[B_TC]), 32'd1);
    rd(2'd1, v); chk("R6 address after reload", v, 32'h0000_800C);

    // R7 error stop and resume
    wr(2'd0, mk(0, 1, 0, 2'b00, 0, 1, 0, 0, 0, 1, 1));
    wr(2'd1, 32'h0000_A000);
    wr(2'd2, 32'd40);
    lb = nlog;
    err_word = nlog + 2;
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0));
    wait_idle();
    chk("R7 stop after error word", nlog - lb, 3);
    rd(2'd0, v);
    chk("R7 err pend", 32'(v[B_EP]), 32'd1);
    chk("R7 no tc", 32'(v[B_TC]), 32'd0);
    chk("R8 irq on error", 32'(irq), 32'd1);
    rd(2'd2, v); chk("R7 count at stop", v, 32'd28);
    err_word = -1;
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 1));
    wait_idle();
    chk("R7 resumed words", nlog - lb, 10);
    rd(2'd0, v);
    chk("R7 err cleared", 32'(v[B_EP]), 32'd0);
    chk("R7 tc after resume", 32'(v[B_TC]), 32'd1);

    // R7 no-stop, R8 masks
    wr(2'd0, mk(0, 1, 0, 2'b00, 0, 1, 1, 1, 0, 1, 1));
    wr(2'd1, 32'h0000_B000);
    wr(2'd2, 32'd24);
    lb = nlog;
    err_word = nlog + 1;
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 1, 1, 0, 0, 0));
    wait_idle();
    err_word = -1;
    chk("R7 no-stop runs on", nlog - lb, 6);
    rd(2'd0, v);
    chk("R7 err flagged", 32'(v[B_EP]), 32'd1);
    chk("R8 tc masked int pend", 32'(v[B_IP]), 32'd0);
    chk("R8 irq masked", 32'(irq), 32'd0);
    wr(2'd0, mk(0, 1, 0, 2'b00, 0, 1, 0, 0, 0, 1, 1));

    // R9 soft reset handshake, manual acknowledge
    auto_mode = 1'b0;
    wr(2'd1, 32'h0000_C000);
    wr(2'd2, 32'd16);
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_req) break;
    end
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 0, 0, 1, 0, 0));
    rd(2'd0, v);
    chk("R9 srst set", 32'(v[B_SR]), 32'd1);
    chk("R9 cycle pending", 32'(v[B_CP]), 32'd1);
    wr(2'd0, mk(1, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0));
    rd(2'd0, v); chk("R9 release refused", 32'(v[B_SR]), 32'd1);
    @(negedge clk) man_ack = 1'b1;
    @(negedge clk) man_ack = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 idle while held", 32'(mem_req), 32'd0);
    end
    rd(2'd2, v); chk("R9 count one word", v, 32'd12);
    wr(2'd0, mk(0, 1, 0, 2'b00, 0, 1, 0, 0, 0, 0, 0));
    rd(2'd0, v); chk("R9 release accepted", 32'(v[B_SR]), 32'd0);

    // R5 collision: last word and write-1-clear of tc on one edge
    wr(2'd0, mk(0, 1, 0, 2'b10, 0, 1, 0, 0, 0, 1, 1));
    wr(2'd1, 32'h0000_D000);
    wr(2'd2, 32'd4);
    wr(2'd0, mk(1, 1, 0, 2'b10, 0, 1, 0, 0, 0, 0, 0));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_req) break;
    end
    man_ack = 1'b1;
    reg_sel = 2'd0; reg_wdata = mk(1, 1, 0, 2'b10, 0, 1, 0, 0, 0, 1, 0); reg_wr = 1'b1;
    @(negedge clk);
    man_ack = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R5 set beats clear", 32'(v[B_TC]), 32'd1);
    rd(2'd2, v); chk("R5 count zero", v, 32'd0);
    wr(2'd0, mk(0, 1, 0, 2'b10, 0, 1, 0, 0, 0, 1, 0));
    rd(2'd0, v); chk("R5 later clear", 32'(v[B_TC]), 32'd0);
    auto_mode = 1'b1;

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total + data_total, bad + data_bad);
    $finish;
  end
endmodule